// File: doc/BRIEF.md
# Split-Word Host Register Bank

This block holds twelve 32-bit control and status words that a host programs over a narrow 16-bit data path. The host uses three control strobes that have no timing relation to the block clock: a register-access select, a write/read direction and a request. The block answers with an acknowledge strobe. Every access has three handshaken phases. The first phase carries the register number on the data lines. The second phase moves the upper half-word and the third phase moves the lower half-word. Each phase is a four-phase request/acknowledge exchange.

On a write, the upper half waits in a staging buffer. The target register takes the full word in a single clock only when the lower half arrives, so consumers of the register outputs never see a torn value. On a read, the whole word is captured when the upper-half phase is taken, and both halves are served from that one capture. Two slots are read-only: a build-time version code and a live converter sample taken from an input. Register numbers 12 to 15 do not exist.

The transfer state machine has six states. XS_IDLE moves to XS_ADDR_ACK when request and select are both seen, and the register number is latched on that move. XS_ADDR_ACK moves to XS_HI_WAIT when request drops. XS_HI_WAIT moves to XS_HI_ACK on request, which stages or captures the word, or back to XS_IDLE if select drops. XS_HI_ACK moves to XS_LO_WAIT when request drops. XS_LO_WAIT moves to XS_LO_ACK on request, which commits the word or serves the lower half, or back to XS_IDLE if select drops. XS_LO_ACK moves to XS_IDLE when request drops.

Top module: `regbank_top`

## Requirements
- R1: While reset is held and right after it, acknowledge is low, the read data output is zero, every writable register and the general-purpose output are zero, and the state machine is idle.
- R2: A write with direction high consists of a number phase (register number on data bits 3:0), an upper-half phase and a lower-half phase. The addressed register then holds {upper, lower}.
- R3: A register changes only in the clock where the lower-half phase is acknowledged. After the upper-half phase alone, its value is unchanged.
- R4: A read with direction low returns the upper half of the addressed register during the upper-half acknowledge and the lower half during the lower-half acknowledge. Both halves come from one capture taken at the upper-half phase.
- R5: Slot 8 always reads the VERSION_CODE parameter and slot 10 always reads the converter input. Writes to these slots change nothing.
- R6: A write to register numbers 12 to 15 leaves every register unchanged. A read from them returns zero in both halves.
- R7: Acknowledge rises only in answer to a request. It stays high while request is high and falls only after request has gone low.
- R8: Each control strobe passes through two synchronising flops. Acknowledge rises on the third rising clock edge after request is first driven high, and never earlier.
- R9: If select drops while the machine waits between phases, the machine returns to idle and discards the staged upper half. The register is unchanged, and the next full access works normally.
- R10: The general-purpose output always carries the value of slot 11.
- R11: A read leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel_i | input | 1 | Register-access select, asynchronous |
| host_wr_i | input | 1 | Direction: 1 write, 0 read, asynchronous |
| host_req_i | input | 1 | Phase request, asynchronous |
| host_ack_o | output | 1 | Phase acknowledge |
| host_data_i | input | HALF_W | Register number or half-word from host |
| host_data_o | output | HALF_W | Half-word returned on reads |
| adc_value_i | input | 2*HALF_W | Converter sample shown in slot 10 |
| regs_o | output | REG_COUNT*2*HALF_W | All slots, slot i at bits [32i+31:32i] |
| gpio_o | output | 2*HALF_W | General-purpose port driven by slot 11 |

## Verification
The bench builds the block with HALF_W of 16, twelve slots and two synchroniser stages. It overrides VERSION_CODE with a distinctive value, so a read-only slot can be told apart from a cleared or written register. These values make every defined slot and all four undefined numbers reachable through the 4-bit number field. The upper-half and lower-half phases can be driven separately, so a test can stop between them to show that nothing commits early. It can also drop select mid-access, or change the converter input between the two halves of a read.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    // Slot numbering; the read-only positions are decoded by the store.
    localparam int SLOT_CFG       = 0;
    localparam int SLOT_BITCOUNT  = 1;
    localparam int SLOT_BIAS      = 2;
    localparam int SLOT_SHUTTER   = 3;
    localparam int SLOT_FRAMES    = 4;
    localparam int SLOT_EXTDAC    = 5;
    localparam int SLOT_PULSEDAC  = 6;
    localparam int SLOT_PULSEPAR  = 7;
    localparam int SLOT_VERSION   = 8;
    localparam int SLOT_ADCCTL    = 9;
    localparam int SLOT_ADCVAL    = 10;
    localparam int SLOT_GPIO      = 11;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_ADDR_ACK,
        XS_HI_WAIT,
        XS_HI_ACK,
        XS_LO_WAIT,
        XS_LO_ACK
    } xfer_state_e;

    function automatic bit slot_is_read_only(input int idx);
        return (idx == SLOT_VERSION) || (idx == SLOT_ADCVAL);
    endfunction

endpackage

// File: rtl/rb_sync.sv
module rb_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/rb_xfer_fsm.sv
module rb_xfer_fsm
    import regbank_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 4,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_s,
    input  logic              sel_s,
    input  logic              wr_s,
    input  logic [HALF_W-1:0] din_i,
    input  logic [WORD_W-1:0] rd_word_i,
    output logic              ack_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              commit_o,
    output logic [WORD_W-1:0] commit_word_o,
    output logic [HALF_W-1:0] dout_o
);

    xfer_state_e state_q, state_d;

    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [HALF_W-1:0] stage_q;
    logic [WORD_W-1:0] rd_hold_q;
    logic [HALF_W-1:0] dout_q;

    logic addr_take, hi_take, lo_take, abort;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:     if (req_s && sel_s) state_d = XS_ADDR_ACK;
            XS_ADDR_ACK: if (!req_s)         state_d = XS_HI_WAIT;
            XS_HI_WAIT: begin
                if (!sel_s)     state_d = XS_IDLE;
                else if (req_s) state_d = XS_HI_ACK;
            end
            XS_HI_ACK:   if (!req_s)         state_d = XS_LO_WAIT;
            XS_LO_WAIT: begin
                if (!sel_s)     state_d = XS_IDLE;
                else if (req_s) state_d = XS_LO_ACK;
            end
            XS_LO_ACK:   if (!req_s)         state_d = XS_IDLE;
            default:                         state_d = XS_IDLE;
        endcase
    end

    // Outputs and phase events
    always_comb begin
        addr_take = (state_q == XS_IDLE) && req_s && sel_s;
        hi_take   = (state_q == XS_HI_WAIT) && sel_s && req_s;
        lo_take   = (state_q == XS_LO_WAIT) && sel_s && req_s;
        abort     = ((state_q == XS_HI_WAIT) || (state_q == XS_LO_WAIT)) && !sel_s;
        ack_o     = (state_q == XS_ADDR_ACK) || (state_q == XS_HI_ACK) ||
                    (state_q == XS_LO_ACK);
        commit_o      = lo_take && wr_q;
        commit_word_o = {stage_q, din_i};
    end

    // Phase datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            addr_q    <= '0;
            stage_q   <= '0;
            rd_hold_q <= '0;
            dout_q    <= '0;
        end else begin
            if (addr_take) begin
                addr_q <= din_i[ADDR_W-1:0];
                wr_q   <= wr_s;
            end
            if (hi_take) begin
                if (wr_q) begin
                    stage_q <= din_i;
                end else begin
                    rd_hold_q <= rd_word_i;
                    dout_q    <= rd_word_i[WORD_W-1:HALF_W];
                end
            end
            if (lo_take && !wr_q) dout_q <= rd_hold_q[HALF_W-1:0];
            if (abort || lo_take) stage_q <= '0;
        end
    end

    assign addr_o = addr_q;
    assign dout_o = dout_q;

endmodule

// File: rtl/rb_store.sv
module rb_store
    import regbank_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int REG_COUNT = 12,
    parameter logic [WORD_W-1:0] VERSION_CODE = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [WORD_W-1:0]           word_i,
    input  logic [WORD_W-1:0]           adc_value_i,
    output logic [WORD_W-1:0]           rd_word_o,
    output logic [REG_COUNT*WORD_W-1:0] regs_o,
    output logic [WORD_W-1:0]           gpio_o
);

    logic [WORD_W-1:0] slot [REG_COUNT];

    generate
        for (genvar g = 0; g < REG_COUNT; g++) begin : g_slot
            if (g == SLOT_VERSION) begin : g_ver
                assign slot[g] = VERSION_CODE;
            end else if (g == SLOT_ADCVAL) begin : g_adc
                assign slot[g] = adc_value_i;
            end else begin : g_rw
                logic [WORD_W-1:0] val_q;
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        val_q <= '0;
                    else if (commit_i && (int'(addr_i) == g))
                        val_q <= word_i;
                end
                assign slot[g] = val_q;
            end
            assign regs_o[g*WORD_W +: WORD_W] = slot[g];
        end
    endgenerate

    // Read-back multiplexer; numbers past the last slot read as zero
    always_comb begin
        rd_word_o = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (int'(addr_i) == i) rd_word_o = slot[i];
        end
    end

    assign gpio_o = slot[SLOT_GPIO];

endmodule

// File: rtl/regbank_top.sv
module regbank_top #(
    parameter int HALF_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int REG_COUNT   = 12,
    parameter int SYNC_STAGES = 2,
    parameter logic [2*HALF_W-1:0] VERSION_CODE = 32'h0002_0001
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_sel_i,
    input  logic                          host_wr_i,
    input  logic                          host_req_i,
    output logic                          host_ack_o,
    input  logic [HALF_W-1:0]             host_data_i,
    output logic [HALF_W-1:0]             host_data_o,
    input  logic [2*HALF_W-1:0]           adc_value_i,
    output logic [REG_COUNT*2*HALF_W-1:0] regs_o,
    output logic [2*HALF_W-1:0]           gpio_o
);

    localparam int WORD_W = 2 * HALF_W;

    logic [2:0]        ctl_s;
    logic [ADDR_W-1:0] addr;
    logic              commit;
    logic [WORD_W-1:0] commit_word;
    logic [WORD_W-1:0] rd_word;

    rb_sync #(
        .WIDTH (3),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({host_sel_i, host_wr_i, host_req_i}),
        .q_o  (ctl_s)
    );

    rb_xfer_fsm #(
        .HALF_W(HALF_W),
        .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_s        (ctl_s[0]),
        .wr_s         (ctl_s[1]),
        .sel_s        (ctl_s[2]),
        .din_i        (host_data_i),
        .rd_word_i    (rd_word),
        .ack_o        (host_ack_o),
        .addr_o       (addr),
        .commit_o     (commit),
        .commit_word_o(commit_word),
        .dout_o       (host_data_o)
    );

    rb_store #(
        .WORD_W      (WORD_W),
        .ADDR_W      (ADDR_W),
        .REG_COUNT   (REG_COUNT),
        .VERSION_CODE(VERSION_CODE)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .addr_i     (addr),
        .word_i     (commit_word),
        .adc_value_i(adc_value_i),
        .rd_word_o  (rd_word),
        .regs_o     (regs_o),
        .gpio_o     (gpio_o)
    );

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_req_i,
    input logic                host_ack_o,
    input logic [HALF_W-1:0]   host_data_o,
    input logic [2*HALF_W-1:0] gpio_o
);

    AST_ACK_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack_o) |-> ($past(host_req_i, 1) && $past(host_req_i, 2))); // R8

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack_o && host_req_i) |=> host_ack_o); // R7

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_ack_o) |-> !$past(host_req_i)); // R7

    AST_GPIO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gpio_o) |-> $rose(host_ack_o)); // R3

    AST_DOUT_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(host_data_o) |-> $rose(host_ack_o)); // R4

endmodule

bind regbank_top regbank_chk #(.HALF_W(HALF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req_i (host_req_i),
    .host_ack_o (host_ack_o),
    .host_data_o(host_data_o),
    .gpio_o     (gpio_o)
);

// File: tb/sim_regbank_top.sv
`timescale 1ns/1ps
module sim_regbank_top;

    localparam int HW  = 16;
    localparam int WW  = 32;
    localparam int NR  = 12;
    localparam logic [WW-1:0] VER = 32'hC0DE_0207;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0, wr = 1'b0, req = 1'b0;
    logic          ack;
    logic [HW-1:0] din = '0;
    logic [HW-1:0] dout;
    logic [WW-1:0] adc = 32'h1234_5678;
    logic [NR*WW-1:0] regs;
    logic [WW-1:0] gpio;

    int checks = 0;
    int errors = 0;
    bit hung = 1'b0;

    always #5 clk = ~clk;

    regbank_top #(
        .HALF_W      (HW),
        .ADDR_W      (4),
        .REG_COUNT   (NR),
        .SYNC_STAGES (2),
        .VERSION_CODE(VER)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel_i (sel),
        .host_wr_i  (wr),
        .host_req_i (req),
        .host_ack_o (ack),
        .host_data_i(din),
        .host_data_o(dout),
        .adc_value_i(adc),
        .regs_o     (regs),
        .gpio_o     (gpio)
    );

    function automatic logic [WW-1:0] slot(input int i);
        return regs[i*WW +: WW];
    endfunction

    task automatic check_eq(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_ack(input logic level);
        int n = 0;
        while (ack !== level && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (ack !== level) begin
            hung = 1'b1;
            check_eq("R7 ack timeout", {31'b0, ack}, {31'b0, level});
        end
    endtask

    // One four-phase exchange; returns the read data seen during acknowledge
    task automatic phase(input logic [HW-1:0] d, output logic [HW-1:0] rd);
        din = d;
        req = 1'b1;
        @(negedge clk);
        wait_ack(1'b1);
        rd = dout;
        req = 1'b0;
        wait_ack(1'b0);
    endtask

    task automatic xfer(input logic w, input int addr, input logic [WW-1:0] val,
                        output logic [WW-1:0] rd);
        logic [HW-1:0] h, l, a;
        sel = 1'b1;
        wr  = w;
        phase(HW'(addr), a);
        phase(val[WW-1:HW], h);
        phase(val[HW-1:0], l);
        sel = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd = {h, l};
    endtask

    task automatic t_reset;
        check_eq("R1 ack after reset", {31'b0, ack}, 32'h0);
        check_eq("R1 dout after reset", {16'b0, dout}, 32'h0);
        for (int i = 0; i < NR; i++) begin
            if (i == 8)       check_eq("R1/R5 version slot", slot(i), VER);
            else if (i == 10) check_eq("R1/R5 adc slot", slot(i), adc);
            else              check_eq("R1 writable slot zero", slot(i), 32'h0);
        end
        check_eq("R1 gpio zero", gpio, 32'h0);
    endtask

    task automatic t_sync_latency;
        logic [HW-1:0] t;
        sel = 1'b1; wr = 1'b1; din = 16'd0; req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_eq("R8 ack low after two edges", {31'b0, ack}, 32'h0);
        @(negedge clk);
        check_eq("R8 ack high on third edge", {31'b0, ack}, 32'h1);
        req = 1'b0;
        @(negedge clk);
        check_eq("R7 ack held until req seen low", {31'b0, ack}, 32'h1);
        wait_ack(1'b0);
        phase(16'hA5A5, t);
        phase(16'h0F0F, t);
        sel = 1'b0;
        @(negedge clk);
        check_eq("R2 cfg write", slot(0), 32'hA5A5_0F0F);
    endtask

    task automatic t_write_read;
        logic [WW-1:0] rd;
        logic [WW-1:0] pat [4];
        int            adr [4];
        pat[0] = 32'hDEAD_BEEF; adr[0] = 1;
        pat[1] = 32'h0000_FFFF; adr[1] = 2;
        pat[2] = 32'hFFFF_0000; adr[2] = 7;
        pat[3] = 32'h8001_7FFE; adr[3] = 9;
        for (int i = 0; i < 4; i++) begin
            xfer(1'b1, adr[i], pat[i], rd);
            check_eq("R2 slot after write", slot(adr[i]), pat[i]);
        end
        for (int i = 0; i < 4; i++) begin
            xfer(1'b0, adr[i], 32'h5555_AAAA, rd);
            check_eq("R4 read back", rd, pat[i]);
            check_eq("R11 read leaves slot", slot(adr[i]), pat[i]);
        end
    endtask

    task automatic t_partial;
        logic [HW-1:0] t;
        sel = 1'b1; wr = 1'b1;
        phase(16'd5, t);
        phase(16'h1357, t);
        repeat (3) @(negedge clk);
        check_eq("R3 no change after upper half", slot(5), 32'h0);
        phase(16'h9BDF, t);
        sel = 1'b0;
        @(negedge clk);
        check_eq("R3 commit on lower half", slot(5), 32'h1357_9BDF);
    endtask

    task automatic t_abort;
        logic [HW-1:0] t;
        logic [WW-1:0] rd;
        sel = 1'b1; wr = 1'b1;
        phase(16'd3, t);
        phase(16'hBAD0, t);
        sel = 1'b0;
        repeat (5) @(negedge clk);
        check_eq("R9 ack low after abort", {31'b0, ack}, 32'h0);
        check_eq("R9 slot unchanged after abort", slot(3), 32'h0);
        xfer(1'b1, 3, 32'h2468_ACE0, rd);
        check_eq("R9 next access works", slot(3), 32'h2468_ACE0);
    endtask

    task automatic t_readonly;
        logic [WW-1:0] rd;
        logic [HW-1:0] h, l, a;
        xfer(1'b1, 8, 32'h1111_2222, rd);
        check_eq("R5 version not writable", slot(8), VER);
        xfer(1'b0, 8, 32'h0, rd);
        check_eq("R5 version read", rd, VER);
        xfer(1'b1, 10, 32'h3333_4444, rd);
        check_eq("R5 adc slot not writable", slot(10), adc);
        adc = 32'h0BAD_F00D;
        xfer(1'b0, 10, 32'h0, rd);
        check_eq("R5 adc read live", rd, 32'h0BAD_F00D);
        sel = 1'b1; wr = 1'b0;
        phase(16'd10, a);
        phase(16'h0, h);
        adc = 32'h7777_8888;
        phase(16'h0, l);
        sel = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_eq("R4 halves from one capture", {h, l}, 32'h0BAD_F00D);
    endtask

    task automatic t_undef;
        logic [NR*WW-1:0] snap;
        logic [WW-1:0]    rd;
        snap = regs;
        xfer(1'b1, 12, 32'hFFFF_FFFF, rd);
        xfer(1'b1, 15, 32'hCAFE_CAFE, rd);
        for (int i = 0; i < NR; i++)
            check_eq("R6 undefined write ignored", slot(i), snap[i*WW +: WW]);
        xfer(1'b0, 13, 32'h0, rd);
        check_eq("R6 undefined read zero", rd, 32'h0);
    endtask

    task automatic t_gpio;
        logic [WW-1:0] rd;
        xfer(1'b1, 11, 32'hF00F_0FF0, rd);
        check_eq("R10 gpio follows slot 11", gpio, 32'hF00F_0FF0);
        xfer(1'b1, 11, 32'h0000_0001, rd);
        check_eq("R10 gpio second value", gpio, 32'h0000_0001);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync_latency();
        t_write_read();
        t_partial();
        t_abort();
        t_readonly();
        t_undef();
        t_gpio();
        if (hung) $display("note: handshake timeouts occurred");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule